// File: doc/BRIEF.md
# Paged Nonvolatile Write Controller

This block is a cycle-based model of the write side of a byte-wide paged nonvolatile memory. The host presents single-cycle byte strobes, each with a 19-bit address and an 8-bit data value. Address bits 7:0 pick a byte slot inside a 256-byte page, and bits 18:8 name the page. The first strobe accepted while idle opens a load window and fixes the page. Later strobes on that page fill or overwrite slots in a page buffer and mark each slot as loaded.

The window closes once no byte has been accepted for a set number of cycles. The controller then raises `busy` for a fixed programming time. At the last cycle of that time it copies the loaded slots, and only those, into a behavioural storage array. It then clears every slot mark. Strobes that arrive during programming are dropped. A strobe that names a different page during loading is dropped as well, and it sets a sticky error flag.

A registered read port returns array contents, so the result of each commit can be seen. To keep elaboration small, the array holds only `2**PAGE_SEL_W` pages. Page numbers that agree in their low `PAGE_SEL_W` bits map to the same stored page.

Top module: `pgwr_ctrl`

## Requirements
- R1: After reset, `busy` and `page_error` are 0 and every byte of the storage array reads as 0x00.
- R2: While idle (`busy` low, no window open), an asserted `wr_stb` opens a load window, latches page bits 18:8, and loads `wr_data` into slot `wr_addr[7:0]`. Later strobes on the same page load their slots as well.
- R3: A strobe is accepted if it arrives no more than `BLC_CYCLES` cycles after the previously accepted byte. After `BLC_CYCLES` cycles with no accepted byte, `busy` goes high on the next cycle. A strobe one cycle later than that limit is not loaded.
- R4: `busy` stays high for exactly `PROG_CYCLES` cycles. The array is unchanged while `busy` is high, and it holds the new data from the cycle in which `busy` falls.
- R5: A commit writes only the slots loaded in that window. Every other byte of the page keeps its earlier value.
- R6: Slots may be loaded in any order. When a slot is loaded more than once in a window, the last value is the one committed.
- R7: During loading, a strobe whose page bits differ from the latched page is ignored and sets `page_error`. The flag stays set, across the commit as well, until the strobe that opens the next load window clears it.
- R8: Strobes while `busy` is high have no effect. They write nothing, open no window and do not set `page_error`.
- R9: Slot marks are cleared when a commit ends, so a later window commits only its own slots.
- R10: A window may load all 256 slots of a page, and the commit then writes all 256.
- R11: `rd_data` shows the stored byte at `rd_addr` one cycle after the address is presented. Stored page = `rd_addr[8+PAGE_SEL_W-1:8]`; higher page bits are not decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | Byte write strobe, one cycle per byte |
| wr_addr | input | 19 | Write address: page in 18:8, slot in 7:0 |
| wr_data | input | 8 | Write data byte |
| rd_addr | input | 19 | Read address |
| rd_data | output | 8 | Registered read data |
| busy | output | 1 | High while the programming timer runs |
| page_error | output | 1 | Sticky flag for a strobe that named a different page |

## Verification
Most internal state in this block shows at the ports only late. A slot mark that is set wrongly or never cleared is invisible until the next commit. It then appears on `rd_data` as a changed byte in a slot that was never loaded, so the bench reads untouched neighbours after every commit. An error in the gap counter or the programming counter shows directly as an early or late edge on `busy`, so the bench counts both intervals to the exact cycle. A buffer slot with the wrong value shows as a wrong byte on the first read after `busy` falls.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int ADDR_W = 19;
    localparam int DATA_W = 8;
    localparam int OFS_W  = 8;
    localparam int PAGE_W = ADDR_W - OFS_W;
    localparam int PAGE_BYTES = 1 << OFS_W;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PROG = 2'd2
    } seq_st_t;

    typedef struct packed {
        logic               we;
        logic [OFS_W-1:0]   ofs;
        logic [DATA_W-1:0]  data;
    } buf_wr_t;

    function automatic logic [PAGE_W-1:0] page_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:OFS_W];
    endfunction

    function automatic logic [OFS_W-1:0] ofs_of(input logic [ADDR_W-1:0] a);
        return a[OFS_W-1:0];
    endfunction
endpackage

// File: rtl/pgwr_seq.sv
module pgwr_seq
    import pgwr_pkg::*;
#(
    parameter int BLC_CYCLES  = 16,
    parameter int PROG_CYCLES = 40
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_stb,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    output seq_st_t             st,
    output buf_wr_t             buf_wr,
    output logic                commit,
    output logic [PAGE_W-1:0]   cur_page,
    output logic                page_error
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int CNT_MAX = (BLC_CYCLES > PROG_CYCLES) ? BLC_CYCLES : PROG_CYCLES;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] GAP_LAST  = CNT_W'(BLC_CYCLES - 1);
    localparam logic [CNT_W-1:0] PROG_LAST = CNT_W'(PROG_CYCLES - 1);

    logic [CNT_W-1:0] cnt;
    logic same_page, open_hit, load_hit, load_miss;

    always_comb begin
        same_page = (page_of(wr_addr) == cur_page);
        open_hit  = (st == ST_IDLE) && wr_stb;
        load_hit  = (st == ST_LOAD) && wr_stb && same_page;
        load_miss = (st == ST_LOAD) && wr_stb && !same_page;
        buf_wr.we   = open_hit || load_hit;
        buf_wr.ofs  = ofs_of(wr_addr);
        buf_wr.data = wr_data;
        commit      = (st == ST_PROG) && (cnt == PROG_LAST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            cnt        <= '0;
            cur_page   <= '0;
            page_error <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (wr_stb) begin
                        st         <= ST_LOAD;
                        cur_page   <= page_of(wr_addr);
                        cnt        <= '0;
                        page_error <= 1'b0;
                    end
                end
                ST_LOAD: begin
                    if (load_miss)
                        page_error <= 1'b1;
                    if (load_hit) begin
                        cnt <= '0;
                    end else if (cnt == GAP_LAST) begin
                        st  <= ST_PROG;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_PROG: begin
                    if (cnt == PROG_LAST) begin
                        st  <= ST_IDLE;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    st  <= ST_IDLE;
                    cnt <= '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/pgwr_page_buf.sv
module pgwr_page_buf
    import pgwr_pkg::*;
(
    input  logic                                clk,
    input  logic                                rst,
    input  buf_wr_t                             buf_wr,
    input  logic                                clear,
    output logic [PAGE_BYTES-1:0][DATA_W-1:0]   slot_data,
    output logic [PAGE_BYTES-1:0]               slot_valid
);
    timeunit 1ns;
    timeprecision 1ps;

    always_ff @(posedge clk) begin
        if (buf_wr.we)
            slot_data[buf_wr.ofs] <= buf_wr.data;
    end

    always_ff @(posedge clk) begin
        if (rst || clear)
            slot_valid <= '0;
        else if (buf_wr.we)
            slot_valid[buf_wr.ofs] <= 1'b1;
    end
endmodule

// File: rtl/pgwr_array.sv
module pgwr_array
    import pgwr_pkg::*;
#(
    parameter int PAGE_SEL_W = 2
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                commit,
    input  logic [PAGE_W-1:0]                   commit_page,
    input  logic [PAGE_BYTES-1:0][DATA_W-1:0]   slot_data,
    input  logic [PAGE_BYTES-1:0]               slot_valid,
    input  logic [ADDR_W-1:0]                   rd_addr,
    output logic [DATA_W-1:0]                   rd_data
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int IDX_W = PAGE_SEL_W + OFS_W;
    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [IDX_W-1:0]  rd_idx;
    logic              unused_hi;

    assign rd_idx    = rd_addr[IDX_W-1:0];
    assign unused_hi = ^{rd_addr[ADDR_W-1:IDX_W], commit_page[PAGE_W-1:PAGE_SEL_W]};

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= '0;
        end else if (commit) begin
            for (int b = 0; b < PAGE_BYTES; b++) begin
                if (slot_valid[b])
                    mem[{commit_page[PAGE_SEL_W-1:0], OFS_W'(b)}] <= slot_data[b];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rd_data <= '0;
        else
            rd_data <= mem[rd_idx];
    end
endmodule

// File: rtl/pgwr_ctrl.sv
module pgwr_ctrl
    import pgwr_pkg::*;
#(
    parameter int BLC_CYCLES  = 16,
    parameter int PROG_CYCLES = 40,
    parameter int PAGE_SEL_W  = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_stb,
    input  logic [18:0] wr_addr,
    input  logic [7:0]  wr_data,
    input  logic [18:0] rd_addr,
    output logic [7:0]  rd_data,
    output logic        busy,
    output logic        page_error
);
    timeunit 1ns;
    timeprecision 1ps;

    seq_st_t                            seq_state;
    buf_wr_t                            buf_wr;
    logic                               commit;
    logic [PAGE_W-1:0]                  cur_page;
    logic [PAGE_BYTES-1:0][DATA_W-1:0]  slot_data;
    logic [PAGE_BYTES-1:0]              slot_valid;

    pgwr_seq #(
        .BLC_CYCLES (BLC_CYCLES),
        .PROG_CYCLES(PROG_CYCLES)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .wr_stb    (wr_stb),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .st        (seq_state),
        .buf_wr    (buf_wr),
        .commit    (commit),
        .cur_page  (cur_page),
        .page_error(page_error)
    );

    pgwr_page_buf u_buf (
        .clk       (clk),
        .rst       (rst),
        .buf_wr    (buf_wr),
        .clear     (commit),
        .slot_data (slot_data),
        .slot_valid(slot_valid)
    );

    pgwr_array #(
        .PAGE_SEL_W(PAGE_SEL_W)
    ) u_array (
        .clk        (clk),
        .rst        (rst),
        .commit     (commit),
        .commit_page(cur_page),
        .slot_data  (slot_data),
        .slot_valid (slot_valid),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data)
    );

    assign busy = (seq_state == ST_PROG);
endmodule

// File: rtl/pgwr_ctrl_chk.sv
module pgwr_ctrl_chk
    import pgwr_pkg::*;
#(
    parameter int PROG_CYCLES = 40
) (
    input logic        clk,
    input logic        rst,
    input logic        wr_stb,
    input logic        busy,
    input logic        page_error,
    input logic [18:0] rd_addr,
    input logic [7:0]  rd_data,
    input seq_st_t     st
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int BW = $clog2(PROG_CYCLES + 1);
    logic [BW-1:0] busy_cnt;

    always_ff @(posedge clk) begin
        if (rst)
            busy_cnt <= '0;
        else if (busy)
            busy_cnt <= busy_cnt + 1'b1;
        else
            busy_cnt <= '0;
    end

    AST_PROG_NOT_LONG: assert property (@(posedge clk) disable iff (rst)
        busy |-> (busy_cnt < BW'(PROG_CYCLES))); // R4

    AST_PROG_FULL_LEN: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> ($past(busy_cnt) == BW'(PROG_CYCLES - 1))); // R4

    AST_ARRAY_HELD: assert property (@(posedge clk) disable iff (rst)
        (busy && $stable(rd_addr)) |=> $stable(rd_data)); // R4

    AST_PROG_AFTER_LOAD: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ($past(st) == ST_LOAD)); // R3

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (page_error && !(st == ST_IDLE && wr_stb)) |=> page_error); // R7

    AST_ERR_CLEAR_ON_OPEN: assert property (@(posedge clk) disable iff (rst)
        $fell(page_error) |-> $past(st == ST_IDLE && wr_stb)); // R7

    AST_BUSY_STB_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_stb) |=> (st != ST_LOAD)); // R8

    AST_BUSY_NO_ERR: assert property (@(posedge clk) disable iff (rst)
        busy |=> !$rose(page_error)); // R8
endmodule

bind pgwr_ctrl pgwr_ctrl_chk #(
    .PROG_CYCLES(PROG_CYCLES)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_stb    (wr_stb),
    .busy      (busy),
    .page_error(page_error),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .st        (seq_state)
);

// File: tb/pgwr_ctrl_bench.sv
module pgwr_ctrl_bench;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int BLC  = 16;
    localparam int PROG = 40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_stb = 1'b0;
    logic [18:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [18:0] rd_addr = '0;
    logic [7:0]  rd_data;
    logic        busy, page_error;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    logic [7:0] ref_mem [1024];

    typedef struct {
        logic [18:0] a;
        logic [7:0]  exp;
        string       req;
        int          due;
    } sb_item_t;
    sb_item_t sb[$];

    pgwr_ctrl #(.BLC_CYCLES(BLC), .PROG_CYCLES(PROG), .PAGE_SEL_W(2)) u_pgwr_ctrl (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .page_error(page_error)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // monitor: compares read results as they come out of the design
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            chk(rd_data == sb[0].exp, $sformatf("%s rd@%05h", sb[0].req, sb[0].a),
                rd_data, sb[0].exp);
            void'(sb.pop_front());
        end
    end

    // driver: present a read address and push its expected byte
    task automatic rd_exp(input logic [18:0] a, input string req);
        rd_addr = a;
        sb.push_back('{a: a, exp: ref_mem[a[9:0]], req: req, due: cyc + 1});
        @(negedge clk);
    endtask

    task automatic put(input logic [18:0] a, input logic [7:0] d);
        wr_stb = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_busy(output int n);
        n = 0;
        while (!busy && n < 1000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic wait_free(output int m);
        m = 0;
        while (busy && m < 1000) begin
            m++;
            @(negedge clk);
        end
    endtask

    task automatic drain();
        idle(2);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        finish_run();
    end

    initial begin
        int n, m;
        foreach (ref_mem[i]) ref_mem[i] = 8'h00;

        // reset
        idle(3);
        rst = 1'b0;
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk(page_error == 1'b0, "R1 page_error", page_error, 0);
        rd_exp(19'h00000, "R1");
        rd_exp(19'h003FF, "R1");
        rd_exp(19'h00155, "R1");
        drain();

        // R2/R6: out-of-order loads with a reload, last byte at the gap limit (R3)
        put(19'h00105, 8'h11);
        put(19'h00103, 8'h22);
        put(19'h00105, 8'h33);
        idle(2);
        put(19'h001FF, 8'h44);
        idle(BLC - 1);
        put(19'h00100, 8'h55);
        chk(busy == 1'b0, "R2 busy during load", busy, 0);
        wait_busy(n);
        chk(n == BLC, "R3 gap before busy", n, BLC);
        rd_exp(19'h00105, "R4 array held while busy");
        wait_free(m);
        chk(m + 1 == PROG, "R4 busy length", m + 1, PROG);
        ref_mem[10'h105] = 8'h33; ref_mem[10'h103] = 8'h22;
        ref_mem[10'h1FF] = 8'h44; ref_mem[10'h100] = 8'h55;
        rd_exp(19'h00105, "R6 reload wins");
        rd_exp(19'h00103, "R2");
        rd_exp(19'h001FF, "R2");
        rd_exp(19'h00100, "R3 byte at limit");
        rd_exp(19'h00101, "R5 untouched");
        rd_exp(19'h00104, "R5 untouched");
        rd_exp(19'h001FE, "R5 untouched");
        drain();

        // R3: byte one cycle past the limit is not loaded; R8 it is dropped
        put(19'h00120, 8'h01);
        idle(BLC);
        chk(busy == 1'b1, "R3 busy after gap", busy, 1);
        put(19'h00121, 8'h02);
        wait_free(m);
        idle(BLC + 4);
        chk(busy == 1'b0, "R8 no window from busy strobe", busy, 0);
        chk(page_error == 1'b0, "R8 no error from busy strobe", page_error, 0);
        ref_mem[10'h120] = 8'h01;
        rd_exp(19'h00120, "R3");
        rd_exp(19'h00121, "R8 dropped byte");
        drain();

        // R7: foreign page strobe is ignored and flagged
        put(19'h00200, 8'hA1);
        put(19'h00300, 8'hB2);
        chk(page_error == 1'b1, "R7 flag set", page_error, 1);
        put(19'h00201, 8'hA2);
        chk(page_error == 1'b1, "R7 flag sticky", page_error, 1);
        wait_busy(n);
        wait_free(m);
        chk(page_error == 1'b1, "R7 flag kept after commit", page_error, 1);
        ref_mem[10'h200] = 8'hA1; ref_mem[10'h201] = 8'hA2;
        rd_exp(19'h00200, "R7");
        rd_exp(19'h00201, "R7");
        rd_exp(19'h00300, "R7 foreign page untouched");
        drain();
        put(19'h00000, 8'h5A);
        chk(page_error == 1'b0, "R7 flag cleared on open", page_error, 0);
        wait_busy(n);
        // R8: strobe while busy
        put(19'h00010, 8'h77);
        chk(page_error == 1'b0, "R8 no flag", page_error, 0);
        wait_free(m);
        ref_mem[10'h000] = 8'h5A;
        rd_exp(19'h00000, "R2");
        rd_exp(19'h00010, "R8 busy write dropped");
        drain();

        // R9: stale slot mark would rewrite slot 0 on page 3
        put(19'h00305, 8'h66);
        wait_busy(n);
        wait_free(m);
        ref_mem[10'h305] = 8'h66;
        rd_exp(19'h00305, "R9");
        rd_exp(19'h00300, "R9 slot marks cleared");
        drain();

        // R10: full page, descending order
        for (int i = 255; i >= 0; i--) begin
            put({11'h002, 8'(i)}, 8'(i) ^ 8'hC3);
            ref_mem[{2'd2, 8'(i)}] = 8'(i) ^ 8'hC3;
        end
        wait_busy(n);
        chk(n == BLC, "R10 gap before busy", n, BLC);
        wait_free(m);
        for (int i = 0; i < 256; i++)
            rd_exp({11'h002, 8'(i)}, "R10");
        drain();

        // R11: read latency and page aliasing
        rd_exp(19'h7FC00, "R11 alias of page 0");
        rd_exp(19'h00405, "R11 alias of page 0");
        rd_exp(19'h00B05, "R11 alias of page 3");
        rd_exp(19'h001FF, "R11");
        drain();

        finish_run();
    end
endmodule